// File: doc/BRIEF.md
# Multi-Channel Match Timer with Snapshot

This block is a bank of up-counting timers on a small word-wide register bus with separate read and write strobes. Each timer counts once per clock while its enable bit is set. It compares its count against several match values. When a match occurs on a comparator that software has marked as the reload source, the count is replaced by a programmable preload value instead of stepping up by one.

Every match sets a sticky status bit. Status bits are cleared by writing ones to a clear register. Each timer drives one interrupt line, formed from its status bits masked by its interrupt-enable bits. A running count is never read directly. Software writes a request to a per-timer capture register. A fixed number of clocks later, that register holds a frozen copy of the count, which it keeps until the next request.

Top module: `match_timer_bank`

## Requirements
- R1: After reset, every count is 0, every timer is stopped, and all match, preload, reload-select, status, enable, count-enable and capture registers read 0, with all interrupt lines low.
- R2: Match register c of timer t sits at word address 3*t+c (0x00-0x08). The other registers are preload at 0x10+t, reload select at 0x14+t, status at 0x18+t, interrupt enable at 0x1C+t, status clear at 0x20+t, count enable at 0x24 and capture at 0x28+t. Written values read back, and untouched registers read 0. A read strobe sampled at one edge presents its data after that edge.
- R3: Bit t of the count-enable register runs timer t. A running timer adds 1 at each clock, and a stopped timer holds its count.
- R4: When a running count equals match c and bit c of that timer's reload-select register is 1, the next count is the preload value. A comparator whose select bit is 0 never reloads.
- R5: With no reload, a count of 0xFFFFFFFF steps to 0.
- R6: Writing a word with bit 0 set to capture register t samples the count as it stood before that write edge. The sampled value appears in the register at the 4th rising edge after the write edge. Earlier reads return the previous capture.
- R7: A running timer whose count equals match c sets status bit c, which then stays set.
- R8: Writing to clear register t clears each status bit whose data bit is 1 and leaves the others unchanged. The clear register reads 0.
- R9: Interrupt line t is high exactly when some status bit of timer t is set together with its enable bit.
- R10: The timers are independent: each counts, reloads and captures only from its own registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for counting and the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 6 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 6 | Word address of the read |
| rd_data | output | 32 | Registered read data, valid after the strobe's edge |
| irq | output | N_TMR (3) | One interrupt line per timer |

## Verification
Read data is due one edge after its strobe, and interrupt lines follow status and enable registers in the same cycle. A status bit sets one edge after the count equals a match, and a capture lands four edges after its request. The bench records the edge number at which each write is sampled. It predicts a count as a function of the edges elapsed since the enable write, including the reload and wrap points. It places capture requests at chosen edges, then queues reads on the 1st and 4th edges after a request, which must return the old value, and on the 5th edge, which must return the new one. A monitor compares each read one edge after its strobe, and interrupt lines are sampled on the falling edge after the write that changes them.

// File: rtl/tmr_pkg.sv
// Shared constants for the match timer bank: bus widths and register bases.
// Assumes at most four timers, so every per-timer block fits in four words,
// and at most sixteen match registers.
package tmr_pkg;
    localparam int unsigned AW = 6;
    localparam int unsigned DW = 32;

    localparam logic [AW-1:0] A_PRELOAD = 6'h10;
    localparam logic [AW-1:0] A_RSEL    = 6'h14;
    localparam logic [AW-1:0] A_STAT    = 6'h18;
    localparam logic [AW-1:0] A_IE      = 6'h1C;
    localparam logic [AW-1:0] A_CLR     = 6'h20;
    localparam logic [AW-1:0] A_CEN     = 6'h24;
    localparam logic [AW-1:0] A_CAP     = 6'h28;
endpackage

// File: rtl/tmr_channel.sv
// One timer: counter, its match comparators, reload choice, sticky status
// and the masked interrupt. Register writes arrive as decoded strobes.
// Assumes the parent provides one clock and a synchronous active-low reset.
module tmr_channel #(
    parameter int unsigned CW    = 32,
    parameter int unsigned N_CMP = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run,
    input  logic [N_CMP-1:0]            match_we,
    input  logic                        pre_we,
    input  logic                        sel_we,
    input  logic                        ie_we,
    input  logic                        clr_we,
    input  logic [CW-1:0]               wdata,
    output logic [CW-1:0]               count_q,
    output logic [N_CMP-1:0][CW-1:0]    match_q,
    output logic [CW-1:0]               preload_q,
    output logic [N_CMP-1:0]            sel_q,
    output logic [N_CMP-1:0]            ie_q,
    output logic [N_CMP-1:0]            status_q,
    output logic                        reload,
    output logic                        irq
);
    logic [N_CMP-1:0] hit;
    logic [N_CMP-1:0] clr_mask;

    // One comparator per match register, live only while the timer runs.
    for (genvar gc = 0; gc < N_CMP; gc++) begin : g_cmp
        assign hit[gc] = run && (count_q == match_q[gc]);

        // Match register storage.
        always_ff @(posedge clk) begin
            if (!rst_n)            match_q[gc] <= '0;
            else if (match_we[gc]) match_q[gc] <= wdata;
        end
    end

    assign reload   = |(hit & sel_q);
    assign clr_mask = clr_we ? wdata[N_CMP-1:0] : '0;
    assign irq      = |(status_q & ie_q);

    // Counter: reload on a selected match, otherwise step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (reload) count_q <= preload_q;
        else if (run)    count_q <= count_q + 1'b1;
    end

    // Preload, reload-select and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload_q <= '0;
            sel_q     <= '0;
            ie_q      <= '0;
        end else begin
            if (pre_we) preload_q <= wdata;
            if (sel_we) sel_q     <= wdata[N_CMP-1:0];
            if (ie_we)  ie_q      <= wdata[N_CMP-1:0];
        end
    end

    // Sticky status: a match in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | hit;
    end
endmodule

// File: rtl/tmr_snapshot.sv
// Capture path for one timer: a request stores the count in a staging
// register, which is published DLY clocks later. A new request restarts it.
// Assumes DLY is at least 1.
module tmr_snapshot #(
    parameter int unsigned CW  = 32,
    parameter int unsigned DLY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [CW-1:0] src,
    output logic [CW-1:0] snap_q
);
    localparam int unsigned DLY_W = $clog2(DLY + 1);

    logic [CW-1:0]    stage_q;
    logic [DLY_W-1:0] wait_q;
    logic             busy_q;

    // Stage on request, count down, then publish to the readable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            wait_q  <= '0;
            busy_q  <= 1'b0;
            snap_q  <= '0;
        end else if (req) begin
            stage_q <= src;
            wait_q  <= DLY_W'(DLY - 1);
            busy_q  <= 1'b1;
        end else if (busy_q) begin
            if (wait_q == '0) begin
                snap_q <= stage_q;
                busy_q <= 1'b0;
            end else begin
                wait_q <= wait_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/match_timer_bank.sv
// Bank of match timers behind a word-wide register bus. Decodes writes into
// per-timer strobes, holds the shared count-enable register and returns
// registered read data. Assumes N_TMR <= 4 and N_TMR*N_CMP <= 16.
module match_timer_bank import tmr_pkg::*; #(
    parameter int unsigned N_TMR   = 3,
    parameter int unsigned N_CMP   = 3,
    parameter int unsigned CW      = 32,
    parameter int unsigned CAP_DLY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [N_TMR-1:0] irq
);
    logic [N_TMR-1:0]                      cen_q;
    logic [N_TMR-1:0][CW-1:0]              count_q;
    logic [N_TMR-1:0][CW-1:0]              snap_q;
    logic [N_TMR-1:0][CW-1:0]              preload_q;
    logic [N_TMR-1:0][N_CMP-1:0][CW-1:0]   match_q;
    logic [N_TMR-1:0][N_CMP-1:0]           sel_q;
    logic [N_TMR-1:0][N_CMP-1:0]           ie_q;
    logic [N_TMR-1:0][N_CMP-1:0]           status_q;
    logic [N_TMR-1:0]                      reload_w;
    logic [DW-1:0]                         rd_mux;

    for (genvar gt = 0; gt < N_TMR; gt++) begin : g_tmr
        logic [N_CMP-1:0] match_we;

        for (genvar gc = 0; gc < N_CMP; gc++) begin : g_mwe
            assign match_we[gc] = wr_en && (wr_addr == AW'(gt * N_CMP + gc));
        end

        tmr_channel #(.CW(CW), .N_CMP(N_CMP)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (cen_q[gt]),
            .match_we  (match_we),
            .pre_we    (wr_en && (wr_addr == AW'(A_PRELOAD + gt))),
            .sel_we    (wr_en && (wr_addr == AW'(A_RSEL + gt))),
            .ie_we     (wr_en && (wr_addr == AW'(A_IE + gt))),
            .clr_we    (wr_en && (wr_addr == AW'(A_CLR + gt))),
            .wdata     (wr_data[CW-1:0]),
            .count_q   (count_q[gt]),
            .match_q   (match_q[gt]),
            .preload_q (preload_q[gt]),
            .sel_q     (sel_q[gt]),
            .ie_q      (ie_q[gt]),
            .status_q  (status_q[gt]),
            .reload    (reload_w[gt]),
            .irq       (irq[gt])
        );

        tmr_snapshot #(.CW(CW), .DLY(CAP_DLY)) u_snap (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (wr_en && (wr_addr == AW'(A_CAP + gt)) && wr_data[0]),
            .src    (count_q[gt]),
            .snap_q (snap_q[gt])
        );
    end

    // Shared count-enable register, one bit per timer.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cen_q <= '0;
        else if (wr_en && (wr_addr == A_CEN)) cen_q <= wr_data[N_TMR-1:0];
    end

    // Read selection; unmapped addresses and clear registers return 0.
    always_comb begin
        rd_mux = '0;
        for (int t = 0; t < N_TMR; t++) begin
            for (int c = 0; c < N_CMP; c++) begin
                if (rd_addr == AW'(t * N_CMP + c)) rd_mux = DW'(match_q[t][c]);
            end
            if (rd_addr == AW'(A_PRELOAD + t)) rd_mux = DW'(preload_q[t]);
            if (rd_addr == AW'(A_RSEL + t))    rd_mux = DW'(sel_q[t]);
            if (rd_addr == AW'(A_STAT + t))    rd_mux = DW'(status_q[t]);
            if (rd_addr == AW'(A_IE + t))      rd_mux = DW'(ie_q[t]);
            if (rd_addr == AW'(A_CAP + t))     rd_mux = DW'(snap_q[t]);
        end
        if (rd_addr == A_CEN) rd_mux = DW'(cen_q);
    end

    // Registered read data, updated on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end
endmodule

// File: rtl/tmr_bank_chk.sv
// Property checker for timer 0 of the bank, attached by bind. Tracks the
// age of the last capture request with its own counter.
module tmr_bank_chk import tmr_pkg::*; #(
    parameter int unsigned N_TMR   = 3,
    parameter int unsigned N_CMP   = 3,
    parameter int unsigned CW      = 32,
    parameter int unsigned CAP_DLY = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [DW-1:0]    wr_data,
    input logic [N_TMR-1:0] irq,
    input logic [N_TMR-1:0] cen_q,
    input logic [CW-1:0]    count0,
    input logic [CW-1:0]    preload0,
    input logic             reload0,
    input logic [N_CMP-1:0] status0,
    input logic [CW-1:0]    snap0
);
    logic [7:0] age_q;
    logic       req0;

    assign req0 = wr_en && (wr_addr == A_CAP) && wr_data[0];

    // Cycles since the last capture request on timer 0, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= 8'hFF;
        else if (req0)           age_q <= '0;
        else if (age_q != 8'hFF) age_q <= age_q + 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (irq == '0) && (count0 == '0));

    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cen_q[0] |=> $stable(count0));

    p_step_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_q[0] && !reload0) |=> count0 == $past(count0) + 1'b1);

    p_reload_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reload0 |=> count0 == $past(preload0));

    p_capture_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(snap0)) |-> age_q == 8'(CAP_DLY));

    p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(status0[0]))
            |-> $past(wr_en && (wr_addr == A_CLR) && wr_data[0]));

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> (status0 != '0));
endmodule

bind match_timer_bank tmr_bank_chk #(
    .N_TMR(N_TMR), .N_CMP(N_CMP), .CW(CW), .CAP_DLY(CAP_DLY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq      (irq),
    .cen_q    (cen_q),
    .count0   (count_q[0]),
    .preload0 (preload_q[0]),
    .reload0  (reload_w[0]),
    .status0  (status_q[0]),
    .snap0    (snap_q[0])
);

// File: tb/test_match_timer_bank.sv
// Scoreboard bench: read tasks queue the expected word, a monitor compares
// it one edge later. Counts are predicted from edges since the enable write.
module test_match_timer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [2:0]  irq;

    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic        rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          t_en = 0;
    int          t_stop0 = 1000000000;
    logic [31:0] prev_cap [3] = '{default: 32'h0};

    match_timer_bank i_match_timer_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) rd_seen <= rd_en;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare the registered read data one edge after each strobe.
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) check(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d, output int e);
        @(negedge clk);
        e = cyc + 1;
        wr_en = 1'b1; wr_addr = a; wr_data = d; rd_en = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        wr_en = 1'b0; rd_en = 1'b1; rd_addr = a;
    endtask

    // Idle until the next bus task will be sampled at edge 'target'.
    task automatic wait_edge(input int target);
        while (cyc + 2 < target) idle();
    endtask

    function automatic logic [31:0] f0(input int k);
        int m = k % 10;
        return (m <= 5) ? 32'(m) : 32'hFFFF_FFFC + 32'(m - 6);
    endfunction

    function automatic logic [31:0] count_at(input int t, input int edge_n);
        int k = edge_n - t_en;
        if (t == 0 && edge_n >= t_stop0) k = t_stop0 - t_en;
        case (t)
            0:       return f0(k);
            1:       return (k <= 2) ? 32'(k) : 32'(k + 4);
            default: return 32'(k);
        endcase
    endfunction

    // Capture request, old value at +1 and +4, new value at +5 edges.
    task automatic capture(input int t, input string tag);
        int e;
        logic [31:0] nv;
        bus_write(6'h28 + 6'(t), 32'h1, e);
        nv = count_at(t, e - 1);
        bus_read(6'h28 + 6'(t), prev_cap[t], {tag, " R6 old+1"});
        idle(); idle();
        bus_read(6'h28 + 6'(t), prev_cap[t], {tag, " R6 old+4"});
        bus_read(6'h28 + 6'(t), nv, {tag, " R6 new+5"});
        prev_cap[t] = nv;
    endtask

    initial begin
        int e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        check({29'h0, irq}, 32'h0, "R1 irq");
        foreach (i_rst_addrs[i]) bus_read(i_rst_addrs[i], 32'h0, "R1 reset read");
        // R2 configuration
        bus_write(6'h00, 32'd5, e);            bus_write(6'h01, 32'd3, e);
        bus_write(6'h02, 32'h100, e);          bus_write(6'h10, 32'hFFFF_FFFC, e);
        bus_write(6'h14, 32'h1, e);            bus_write(6'h1C, 32'h4, e);
        bus_write(6'h03, 32'd4, e);            bus_write(6'h04, 32'd2, e);
        bus_write(6'h11, 32'd7, e);            bus_write(6'h15, 32'h2, e);
        bus_write(6'h06, 32'hFFFF_FFFF, e);    bus_write(6'h16, 32'h1, e);
        bus_read(6'h04, 32'd2, "R2 match t1c1");
        bus_read(6'h10, 32'hFFFF_FFFC, "R2 preload t0");
        bus_read(6'h15, 32'h2, "R2 reload select t1");
        bus_read(6'h08, 32'h0, "R2 untouched match t2c2");
        // R3 start all timers together
        bus_write(6'h24, 32'h7, t_en);
        bus_read(6'h24, 32'h7, "R3 enable readback");
        wait_edge(t_en + 1 + 5);  capture(0, "R3 t0 k=5");
        wait_edge(t_en + 1 + 16); capture(0, "R4 t0 reload");
        wait_edge(t_en + 1 + 29); capture(0, "R5 t0 top");
        wait_edge(t_en + 1 + 40); capture(0, "R5 t0 wrap");
        capture(1, "R4 R10 t1 select c1");
        capture(2, "R10 t2 free run");
        // R7 status, R9 interrupt masking
        bus_read(6'h18, 32'h3, "R7 status t0");
        bus_read(6'h19, 32'h6, "R7 status t1");
        bus_read(6'h1A, 32'h6, "R7 status t2");
        idle();
        check({29'h0, irq}, 32'h0, "R9 masked irq");
        bus_write(6'h1D, 32'h2, e);
        idle();
        check({31'h0, irq[1]}, 32'h1, "R9 irq t1 enabled");
        // R8 clear one bit of t1
        bus_write(6'h21, 32'h2, e);
        idle();
        check({31'h0, irq[1]}, 32'h0, "R8 R9 irq after clear");
        bus_read(6'h19, 32'h4, "R8 other bit kept");
        bus_read(6'h21, 32'h0, "R8 clear reads 0");
        // R3 stop timer 0, count holds
        bus_write(6'h24, 32'h6, t_stop0);
        repeat (7) idle();
        capture(0, "R3 t0 held");
        capture(0, "R3 t0 held again");
        bus_write(6'h20, 32'h3, e);
        bus_read(6'h18, 32'h0, "R8 t0 cleared while stopped");
        repeat (3) idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    logic [5:0] i_rst_addrs [8] = '{6'h00, 6'h08, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h24, 6'h28};

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1-all actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule